// File: doc/BRIEF.md
# Hot-Swap Insertion/Extraction Status Register

This block is the board-side status and control register that a hot-pluggable card uses to tell the host about insertion and extraction. It records two hardware events: the board has been seated, and the ejector handle has been opened. From those events it drives an active-low enumeration request toward the host and lights a blue indicator LED whenever the board is not under driver control.

Software reads the register through a simple single-cycle port. It acknowledges events by writing 1 to their bits. It turns the LED off once its driver owns the board. An internal phase machine (idle, inserting, online, extracting) enforces the handshake order. An extraction request counts only after the insertion event has been acknowledged. A completed extraction returns the block to idle until the board is inserted again.

Register layout, 8 bits: bit 7 is the insertion event, bit 6 is the extraction event, bit 3 is the LED control and bit 1 is the enumeration mask. All other bits read 0.

Top module: `hs_swap_csr`

## Requirements
- R1: After reset the register reads 0x08 (LED bit 3 set, all other bits 0), `led_o` is 1 and `enum_n_o` is 1.
- R2: An `insert_ev_i` pulse sets bit 7 and bit 3 at the next clock edge, whatever the phase.
- R3: Bits 7 and 6 are write-1-to-clear. Writing 0 to them leaves them unchanged. A hardware set in the same cycle as a software clear wins, so the bit stays 1.
- R4: An `eject_ev_i` pulse sets bit 6 only in the online phase, that is after bit 7 has been cleared following an insertion. It is ignored while bit 7 is set, while bit 6 is already set, and when it arrives in the same cycle as `insert_ev_i`.
- R5: `enum_n_o` is 0 exactly when (bit 7 or bit 6) is 1 and bit 1 is 0. It follows the register with no added cycle.
- R6: Bit 3 is read/write and `led_o` always equals bit 3. An insertion in the same cycle as a write forces bit 3 to 1.
- R7: Bit 1 is read/write. While it is 1, `enum_n_o` stays 1 even with events pending.
- R8: Bits 5, 4, 2 and 0 always read 0, and writes to them are ignored.
- R9: Clearing bit 6 in the extracting phase returns the block to idle. A later `eject_ev_i` is then ignored until a new insertion has been acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| insert_ev_i | input | 1 | One-cycle pulse: board seated |
| eject_ev_i | input | 1 | One-cycle pulse: ejector handle opened |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Current register value |
| enum_n_o | output | 1 | Enumeration request, active low (open-drain style) |
| led_o | output | 1 | Blue indicator LED drive |

## Verification
The hazardous coincidences are a hardware event landing in the same cycle as a software write to the same bit. One case is an insertion while software clears bit 7 or writes bit 3 to 0. The other is an insertion and an ejector opening in the same online cycle. The bench drives these pairs deliberately in directed steps and also with random stimulus. It judges each cycle against a behavioural reference model that encodes the priority rules: hardware sets win, and insertion beats extraction.

// File: rtl/hs_csr_pkg.sv
`timescale 1ns/1ps
package hs_csr_pkg;
  localparam int unsigned CSR_W    = 8;
  localparam int unsigned INS_BIT  = 7;
  localparam int unsigned EXT_BIT  = 6;
  localparam int unsigned LED_BIT  = 3;
  localparam int unsigned MASK_BIT = 1;
  localparam int unsigned N_EVT    = 2;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_INSERT  = 2'd1,
    PH_ONLINE  = 2'd2,
    PH_EXTRACT = 2'd3
  } phase_e;
endpackage

// File: rtl/hs_evt_bit.sv
`timescale 1ns/1ps
// Sticky event flag: hardware set beats software write-1-to-clear.
module hs_evt_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o,
  output logic d_o
);
  assign d_o = set_i | (q_o & ~clr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= d_o;
  end
endmodule

// File: rtl/hs_cfg_bit.sv
`timescale 1ns/1ps
// Read/write control bit with reset value and hardware force-to-one.
module hs_cfg_bit #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic force_i,
  input  logic wr_i,
  input  logic wdata_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= RST_VAL;
    else if (force_i) q_o <= 1'b1;
    else if (wr_i)    q_o <= wdata_i;
  end
endmodule

// File: rtl/hs_phase_fsm.sv
`timescale 1ns/1ps
module hs_phase_fsm
  import hs_csr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic insert_i,
  input  logic eject_i,
  input  logic ins_d_i,   // next value of insertion flag
  input  logic ext_d_i,   // next value of extraction flag
  output logic ext_set_o
);
  phase_e phase_q, phase_d;

  // Extraction only counts once the insertion has been acknowledged.
  assign ext_set_o = eject_i & ~insert_i & (phase_q == PH_ONLINE);

  always_comb begin
    phase_d = phase_q;
    if (insert_i) begin
      phase_d = PH_INSERT;
    end else begin
      unique case (phase_q)
        PH_INSERT:  if (!ins_d_i) phase_d = ext_d_i ? PH_EXTRACT : PH_ONLINE;
        PH_ONLINE:  if (ext_set_o) phase_d = PH_EXTRACT;
        PH_EXTRACT: if (!ext_d_i) phase_d = PH_IDLE;
        default:    phase_d = phase_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_IDLE;
    else         phase_q <= phase_d;
  end
endmodule

// File: rtl/hs_swap_csr.sv
`timescale 1ns/1ps
module hs_swap_csr
  import hs_csr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             insert_ev_i,
  input  logic             eject_ev_i,
  input  logic             reg_wr_i,
  input  logic [CSR_W-1:0] reg_wdata_i,
  output logic [CSR_W-1:0] reg_rdata_o,
  output logic             enum_n_o,
  output logic             led_o
);
  localparam int unsigned EVT_POS [N_EVT] = '{INS_BIT, EXT_BIT};

  logic [N_EVT-1:0] ev_set, ev_clr, ev_q, ev_d;
  logic ext_set, led_q, mask_q;

  assign ev_set[0] = insert_ev_i;
  assign ev_set[1] = ext_set;

  for (genvar g = 0; g < N_EVT; g++) begin : g_evt
    assign ev_clr[g] = reg_wr_i & reg_wdata_i[EVT_POS[g]];
    hs_evt_bit u_evt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (ev_set[g]),
      .clr_i  (ev_clr[g]),
      .q_o    (ev_q[g]),
      .d_o    (ev_d[g])
    );
  end

  hs_phase_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .insert_i  (insert_ev_i),
    .eject_i   (eject_ev_i),
    .ins_d_i   (ev_d[0]),
    .ext_d_i   (ev_d[1]),
    .ext_set_o (ext_set)
  );

  hs_cfg_bit #(.RST_VAL(1'b1)) u_led (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .force_i (insert_ev_i),
    .wr_i    (reg_wr_i),
    .wdata_i (reg_wdata_i[LED_BIT]),
    .q_o     (led_q)
  );

  hs_cfg_bit #(.RST_VAL(1'b0)) u_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .force_i (1'b0),
    .wr_i    (reg_wr_i),
    .wdata_i (reg_wdata_i[MASK_BIT]),
    .q_o     (mask_q)
  );

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata_i;

  always_comb begin
    reg_rdata_o           = '0;
    reg_rdata_o[INS_BIT]  = ev_q[0];
    reg_rdata_o[EXT_BIT]  = ev_q[1];
    reg_rdata_o[LED_BIT]  = led_q;
    reg_rdata_o[MASK_BIT] = mask_q;
  end

  assign enum_n_o = ~(|ev_q & ~mask_q);
  assign led_o    = led_q;
endmodule

// File: rtl/hs_swap_csr_chk.sv
`timescale 1ns/1ps
module hs_swap_csr_chk
  import hs_csr_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             insert_ev_i,
  input logic             eject_ev_i,
  input logic             reg_wr_i,
  input logic [CSR_W-1:0] reg_wdata_i,
  input logic [CSR_W-1:0] reg_rdata_o,
  input logic             enum_n_o,
  input logic             led_o
);
  AST_INSERT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    insert_ev_i |=> reg_rdata_o[INS_BIT] && led_o); // R2
  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_wdata_i[INS_BIT] && !insert_ev_i) |=> !reg_rdata_o[INS_BIT]); // R3
  AST_EJECT_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eject_ev_i && reg_rdata_o[INS_BIT] && !reg_rdata_o[EXT_BIT]) |=> !reg_rdata_o[EXT_BIT]); // R4
  AST_MASK_HOLDS_ENUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[MASK_BIT] |-> enum_n_o); // R7
  AST_LED_TRACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    led_o == reg_rdata_o[LED_BIT]); // R6
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rdata_o[5] && !reg_rdata_o[4] && !reg_rdata_o[2] && !reg_rdata_o[0]); // R8
  AST_ENUM_NEEDS_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enum_n_o |-> (reg_rdata_o[INS_BIT] || reg_rdata_o[EXT_BIT])); // R5
endmodule

bind hs_swap_csr hs_swap_csr_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .insert_ev_i (insert_ev_i),
  .eject_ev_i  (eject_ev_i),
  .reg_wr_i    (reg_wr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .enum_n_o    (enum_n_o),
  .led_o       (led_o)
);

// File: tb/hs_swap_csr_bench.sv
`timescale 1ns/1ps
module hs_swap_csr_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       insert_ev_i = 1'b0;
  logic       eject_ev_i = 1'b0;
  logic       reg_wr_i = 1'b0;
  logic [7:0] reg_wdata_i = 8'h00;
  logic [7:0] reg_rdata_o;
  logic       enum_n_o;
  logic       led_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  hs_swap_csr u_hs_swap_csr (.*);

  // behavioural reference: 0 idle, 1 inserting, 2 online, 3 extracting
  int m_ins, m_ext, m_led, m_mask, m_ph;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ins = 0; m_ext = 0; m_led = 1; m_mask = 0; m_ph = 0;
    end else begin
      int acc;
      acc = (eject_ev_i && m_ph == 2 && !insert_ev_i) ? 1 : 0;
      if (insert_ev_i) m_ins = 1;
      else if (reg_wr_i && reg_wdata_i[7]) m_ins = 0;
      if (acc == 1) m_ext = 1;
      else if (reg_wr_i && reg_wdata_i[6]) m_ext = 0;
      if (insert_ev_i) m_led = 1;
      else if (reg_wr_i) m_led = int'(reg_wdata_i[3]);
      if (reg_wr_i) m_mask = int'(reg_wdata_i[1]);
      if (insert_ev_i) m_ph = 1;
      else if (m_ph == 1 && m_ins == 0) m_ph = (m_ext == 1) ? 3 : 2;
      else if (m_ph == 2 && acc == 1) m_ph = 3;
      else if (m_ph == 3 && m_ext == 0) m_ph = 0;
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk(int'(reg_rdata_o[7]), m_ins, "R2 bit7 model");
      chk(int'(reg_rdata_o[6]), m_ext, "R4 bit6 model");
      chk(int'(reg_rdata_o[3]), m_led, "R6 bit3 model");
      chk(int'(reg_rdata_o[1]), m_mask, "R7 bit1 model");
      chk(int'({reg_rdata_o[5:4], reg_rdata_o[2], reg_rdata_o[0]}), 0, "R8 reserved bits");
      chk(int'(led_o), m_led, "R6 led_o");
      chk(int'(enum_n_o), ((m_ins | m_ext) & (1 - m_mask)) ? 0 : 1, "R5 enum_n_o");
    end
  end

  task automatic op(input bit ins, input bit ej, input bit wr, input logic [7:0] wd);
    @(posedge clk_i); #1;
    insert_ev_i = ins; eject_ev_i = ej; reg_wr_i = wr; reg_wdata_i = wd;
    @(posedge clk_i); #1;
    insert_ev_i = 0; eject_ev_i = 0; reg_wr_i = 0; reg_wdata_i = 8'h00;
    #1;
  endtask

  task automatic expect_reg(input logic [7:0] exp, input bit en_n, input string tag);
    chk(int'(reg_rdata_o), int'(exp), tag);
    chk(int'(enum_n_o), int'(en_n), tag);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk_i); cyc++;
    end
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    expect_reg(8'h08, 1'b1, "R1 reset value");
    chk(int'(led_o), 1, "R1 led on after reset");
    #2 rst_ni = 1'b1;

    op(1, 0, 0, 8'h00); expect_reg(8'h88, 1'b0, "R2 insert sets bit7/bit3, R5 enum low");
    op(0, 1, 0, 8'h00); expect_reg(8'h88, 1'b0, "R4 eject ignored while bit7 set");
    op(0, 0, 1, 8'h0A); expect_reg(8'h8A, 1'b1, "R7 mask holds enum high");
    op(0, 0, 1, 8'h08); expect_reg(8'h88, 1'b0, "R7 unmask releases enum");
    op(1, 0, 1, 8'h80); expect_reg(8'h88, 1'b0, "R3 set beats clear same cycle");
    op(1, 0, 1, 8'h00); expect_reg(8'h88, 1'b0, "R6 insert forces bit3 over write");
    op(0, 0, 1, 8'h80); expect_reg(8'h00, 1'b1, "R3 W1C bit7, R6 led off");
    chk(int'(led_o), 0, "R6 led follows bit3");
    op(0, 0, 1, 8'h35); expect_reg(8'h00, 1'b1, "R8 reserved writes ignored");
    op(0, 1, 0, 8'h00); expect_reg(8'h40, 1'b0, "R4 eject accepted when online");
    op(0, 1, 0, 8'h00); expect_reg(8'h40, 1'b0, "R4 repeated eject no change");
    op(0, 0, 1, 8'h08); expect_reg(8'h48, 1'b0, "R3 write 0 keeps bit6");
    op(0, 0, 1, 8'h48); expect_reg(8'h08, 1'b1, "R3 W1C bit6");
    op(0, 1, 0, 8'h00); expect_reg(8'h08, 1'b1, "R9 eject ignored after return to idle");
    op(1, 0, 0, 8'h00); op(0, 0, 1, 8'h80);
    op(1, 1, 0, 8'h00); expect_reg(8'h88, 1'b0, "R4 insert beats eject same cycle");

    for (int i = 0; i < 600; i++) begin
      @(posedge clk_i); #1;
      insert_ev_i = ($urandom % 16) == 0;
      eject_ev_i  = ($urandom % 4) == 0;
      reg_wr_i    = ($urandom % 3) == 0;
      reg_wdata_i = 8'($urandom);
    end
    @(posedge clk_i); #1;
    insert_ev_i = 0; eject_ev_i = 0; reg_wr_i = 0;
    repeat (2) @(posedge clk_i);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule